// File: doc/BRIEF.md
# NAND Bus Cycle Timing Engine

This block turns single register writes and reads into bus cycles on an 8-bit raw NAND device. A write to the command port makes a command-latch cycle. A write to the address port makes an address-latch cycle. A write to the data port drives one byte to the device. A read of the data port fetches one byte from the device and returns it on the read-data bus when the cycle completes.

Every cycle has three phases: setup, strobe and hold. The length of each phase comes from a 32-bit timing register. Reads and writes use separate fields, so they can have different phase lengths. After each cycle, a programmable wait runs before the device's ready/busy pin is sampled into a status bit. A config bit can hold chip enable low between cycles. A control bit aborts any cycle and clears the config.

Top module: `nand_bus_timer`

Register map (`addr_i`): 0 data, 1 command, 2 address, 3 control (write only), 4 config, 5 status (read only), 6 timing. Reads of addresses other than 0 return the register on `rdata_o`, with `rvalid_o` high one clock after the request.

## Requirements
- R1: A write to address 1 starts a cycle in which `nand_cle_o` is high and `nand_ale_o` is low for every clock that `busy_o` is high. The write strobe is used for this cycle.
- R2: A write to address 2 starts a cycle in which `nand_ale_o` is high and `nand_cle_o` is low for every clock that `busy_o` is high. The write strobe is used for this cycle.
- R3: A write to address 0 drives `wdata_i[7:0]` on `nand_dq_o`, with `nand_dq_oe_o` high, for the whole cycle. CLE and ALE stay low. A read of address 0 keeps `nand_dq_oe_o` low and captures `nand_dq_i` on the last clock of the strobe phase. When the cycle ends, `rvalid_o` goes high and `rdata_o` holds the captured byte in bits 7:0 and zeros in bits 31:8.
- R4: The timing register is laid out as follows. Bits 31:28 are the write ready-wait, 27:24 the write strobe width, 23:20 the write hold and 19:16 the write setup. Bits 15:12 are the read ready-wait, 11:8 the read strobe width, 7:4 the read hold and 3:0 the read setup. A field value n gives a phase of n+1 clocks. Write cycles use the upper half and read cycles use the lower half.
- R5: `busy_o` goes high on the clock after a cycle is accepted and stays high for setup+width+hold+3 clocks. Data, command and address requests made while `busy_o` is high are ignored.
- R6: `nand_we_no` and `nand_re_no` are active low. They are never low together, and they are low only during the strobe phase of a write or a read cycle respectively.
- R7: `nand_ce_no` is low during every cycle. It is also held low while config bit 0 is 1.
- R8: When a cycle ends, a ready-wait of 2n clocks starts, where n is the ready-wait field for that direction. The status bit 0 (1 means ready) is loaded from `nand_rb_i` only when the wait expires, or on a clock with no cycle and no wait pending.
- R9: Writing 1 to control bit 0 aborts any cycle on the next clock. `busy_o` drops, the strobes go high, the config register clears and the timing register keeps its value.
- R10: After reset, the timing register reads 0xFFFFFFFF, the config reads 0, `busy_o` is low and `nand_ce_no`, `nand_we_no` and `nand_re_no` are high.
- R11: The phase lengths are fixed when a cycle is accepted. A timing write during the cycle does not change that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rvalid_o | output | 1 | Read data valid pulse |
| rdata_o | output | 32 | Read data |
| busy_o | output | 1 | Bus cycle in progress |
| nand_ce_no | output | 1 | Chip enable, active low |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_no | output | 1 | Write strobe, active low |
| nand_re_no | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Data to the device |
| nand_dq_oe_o | output | 1 | Data output enable |
| nand_dq_i | input | 8 | Data from the device |
| nand_rb_i | input | 1 | Ready/busy from the device, 1 = ready |

## Verification
The bench sweeps setup, width and hold over 0 to 3 for every cycle kind. The read fields hold a permutation of the write fields. A design that used the wrong half of the timing register, or an off-by-one phase count, would therefore give the wrong phase length. During read cycles the bench changes the device byte once the hold phase starts. A design that captured late would return the hold-phase byte instead of the strobe-phase byte. Status reads are placed on the exact clocks around the end of the ready-wait, so a wait that is one clock short or long shows up as an early or late ready bit. The bench also issues a second request during a cycle, a timing write during a cycle and a software reset during a cycle. A design that accepted the request, retimed the running cycle, or failed to idle would show it on the latch lines, the strobe width or `busy_o`.

// File: rtl/nbt_pkg.sv
package nbt_pkg;
  localparam int FW     = 4;   // timing field width
  localparam int BW     = 8;   // device bus width
  localparam int RW     = 32;  // register width
  localparam int AW     = 3;   // register address width
  localparam int HALF_W = 4 * FW;

  localparam logic [AW-1:0] A_DATA = 3'd0;
  localparam logic [AW-1:0] A_CMD  = 3'd1;
  localparam logic [AW-1:0] A_ADDR = 3'd2;
  localparam logic [AW-1:0] A_CTRL = 3'd3;
  localparam logic [AW-1:0] A_CFG  = 3'd4;
  localparam logic [AW-1:0] A_STAT = 3'd5;
  localparam logic [AW-1:0] A_TIM  = 3'd6;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} phase_e;
  typedef enum logic [1:0] {K_WDATA, K_CMD, K_ADDR, K_RDATA} kind_e;

  // one direction's timing, msb first
  typedef struct packed {
    logic [FW-1:0] wait_n;
    logic [FW-1:0] width;
    logic [FW-1:0] hold;
    logic [FW-1:0] setup;
  } dir_tim_t;
endpackage

// File: rtl/nbt_regs.sv
module nbt_regs
  import nbt_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [RW-1:0] wdata_i,
  output logic [RW-1:0] timing_o,
  output logic          ce_force_o,
  output logic          soft_rst_o
);
  assign soft_rst_o = wr_en_i && (addr_i == A_CTRL) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      timing_o   <= '1;
      ce_force_o <= 1'b0;
    end else if (soft_rst_o) begin
      ce_force_o <= 1'b0;
    end else if (wr_en_i) begin
      if (addr_i == A_CFG) ce_force_o <= wdata_i[0];
      if (addr_i == A_TIM) timing_o   <= wdata_i;
    end
  end
endmodule

// File: rtl/nbt_phase_seq.sv
module nbt_phase_seq
  import nbt_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          soft_rst_i,
  input  logic          start_i,
  input  kind_e         kind_i,
  input  logic [BW-1:0] byte_i,
  input  dir_tim_t      tim_i,
  input  logic [BW-1:0] dq_i,
  output phase_e        phase_o,
  output kind_e         kind_o,
  output logic [BW-1:0] byte_o,
  output logic [BW-1:0] rd_byte_o,
  output logic [FW-1:0] wait_n_o,
  output logic          cyc_done_o,
  output logic          rd_done_o
);
  logic [FW-1:0] cnt_q;
  dir_tim_t      tim_q;
  logic          last;

  assign last       = (cnt_q == '0);
  assign cyc_done_o = (phase_o == PH_HOLD) && last;
  assign rd_done_o  = cyc_done_o && (kind_o == K_RDATA);
  assign wait_n_o   = tim_q.wait_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_o   <= PH_IDLE;
      kind_o    <= K_WDATA;
      byte_o    <= '0;
      rd_byte_o <= '0;
      cnt_q     <= '0;
      tim_q     <= '0;
    end else if (soft_rst_i) begin
      phase_o <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (phase_o)
        PH_IDLE: if (start_i) begin
          phase_o <= PH_SETUP;
          cnt_q   <= tim_i.setup;
          tim_q   <= tim_i;
          kind_o  <= kind_i;
          byte_o  <= byte_i;
        end
        PH_SETUP: if (last) begin
          phase_o <= PH_STROBE;
          cnt_q   <= tim_q.width;
        end else cnt_q <= cnt_q - 1'b1;
        PH_STROBE: if (last) begin
          phase_o <= PH_HOLD;
          cnt_q   <= tim_q.hold;
          if (kind_o == K_RDATA) rd_byte_o <= dq_i;
        end else cnt_q <= cnt_q - 1'b1;
        PH_HOLD: if (last) phase_o <= PH_IDLE;
                 else cnt_q <= cnt_q - 1'b1;
        default: phase_o <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nbt_rdy_wait.sv
module nbt_rdy_wait
  import nbt_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          soft_rst_i,
  input  logic          cyc_active_i,
  input  logic          cyc_done_i,
  input  logic [FW-1:0] wait_n_i,
  input  logic          rb_i,
  output logic          rdy_o
);
  localparam int CW = FW + 1;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rdy_o <= 1'b0;
    end else if (soft_rst_i) begin
      cnt_q <= '0;
    end else if (cyc_done_i) begin
      cnt_q <= {wait_n_i, 1'b0};  // 2n clocks
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) rdy_o <= rb_i;
    end else if (!cyc_active_i) begin
      rdy_o <= rb_i;
    end
  end
endmodule

// File: rtl/nand_bus_timer.sv
module nand_bus_timer
  import nbt_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [RW-1:0] wdata_i,
  output logic          rvalid_o,
  output logic [RW-1:0] rdata_o,
  output logic          busy_o,
  output logic          nand_ce_no,
  output logic          nand_cle_o,
  output logic          nand_ale_o,
  output logic          nand_we_no,
  output logic          nand_re_no,
  output logic [BW-1:0] nand_dq_o,
  output logic          nand_dq_oe_o,
  input  logic [BW-1:0] nand_dq_i,
  input  logic          nand_rb_i
);
  logic [RW-1:0] timing;
  logic          ce_force, soft_rst;
  phase_e        phase;
  kind_e         kind_q, req_kind;
  logic [BW-1:0] byte_q, rd_byte;
  logic [FW-1:0] wait_n;
  logic          cyc_done, rd_done, rdy;
  logic          wr_req, rd_req, start;
  dir_tim_t      tim_sel;

  nbt_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .timing_o(timing), .ce_force_o(ce_force), .soft_rst_o(soft_rst)
  );

  assign wr_req = wr_en_i && (addr_i == A_DATA || addr_i == A_CMD || addr_i == A_ADDR);
  assign rd_req = rd_en_i && (addr_i == A_DATA);
  assign start  = !busy_o && !soft_rst && (wr_req || rd_req);

  always_comb begin
    if (wr_req) begin
      unique case (addr_i)
        A_CMD:   req_kind = K_CMD;
        A_ADDR:  req_kind = K_ADDR;
        default: req_kind = K_WDATA;
      endcase
    end else req_kind = K_RDATA;
  end

  assign tim_sel = (req_kind == K_RDATA) ? dir_tim_t'(timing[HALF_W-1:0])
                                         : dir_tim_t'(timing[RW-1:HALF_W]);

  nbt_phase_seq u_seq (
    .clk_i, .rst_ni, .soft_rst_i(soft_rst), .start_i(start),
    .kind_i(req_kind), .byte_i(wdata_i[BW-1:0]), .tim_i(tim_sel),
    .dq_i(nand_dq_i), .phase_o(phase), .kind_o(kind_q), .byte_o(byte_q),
    .rd_byte_o(rd_byte), .wait_n_o(wait_n), .cyc_done_o(cyc_done),
    .rd_done_o(rd_done)
  );

  nbt_rdy_wait u_rdy (
    .clk_i, .rst_ni, .soft_rst_i(soft_rst), .cyc_active_i(busy_o),
    .cyc_done_i(cyc_done), .wait_n_i(wait_n), .rb_i(nand_rb_i), .rdy_o(rdy)
  );

  assign busy_o       = (phase != PH_IDLE);
  assign nand_ce_no   = !(busy_o || ce_force);
  assign nand_cle_o   = busy_o && (kind_q == K_CMD);
  assign nand_ale_o   = busy_o && (kind_q == K_ADDR);
  assign nand_we_no   = !((phase == PH_STROBE) && (kind_q != K_RDATA));
  assign nand_re_no   = !((phase == PH_STROBE) && (kind_q == K_RDATA));
  assign nand_dq_o    = byte_q;
  assign nand_dq_oe_o = busy_o && (kind_q != K_RDATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= 1'b0;
      if (rd_done) begin
        rvalid_o <= 1'b1;
        rdata_o  <= {{(RW-BW){1'b0}}, rd_byte};
      end else if (rd_en_i && addr_i != A_DATA) begin
        rvalid_o <= 1'b1;
        unique case (addr_i)
          A_CFG:   rdata_o <= {{(RW-1){1'b0}}, ce_force};
          A_STAT:  rdata_o <= {{(RW-1){1'b0}}, rdy};
          A_TIM:   rdata_o <= timing;
          default: rdata_o <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/nbt_checker.sv
module nbt_checker
  import nbt_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic [AW-1:0] addr_i,
  input logic [RW-1:0] wdata_i,
  input logic          busy_o,
  input logic          nand_ce_no,
  input logic          nand_cle_o,
  input logic          nand_ale_o,
  input logic          nand_we_no,
  input logic          nand_re_no,
  input logic [BW-1:0] nand_dq_o,
  input logic          nand_dq_oe_o,
  input logic          ce_force
);
  a_r6_strobes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!nand_we_no && !nand_re_no));
  a_r6_strobe_in_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nand_we_no || !nand_re_no) |-> busy_o);
  a_r7_ce_in_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !nand_ce_no);
  a_r7_ce_forced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_force |-> !nand_ce_no);
  a_r1_latch_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nand_cle_o && nand_ale_o));
  a_r3_read_undriven: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nand_re_no |-> !nand_dq_oe_o);
  a_r3_write_byte_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && nand_dq_oe_o) |-> $stable(nand_dq_o));
  a_r9_soft_reset_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_CTRL && wdata_i[0]) |=> (!busy_o && nand_ce_no));
endmodule

bind nand_bus_timer nbt_checker u_chk (
  .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .busy_o, .nand_ce_no,
  .nand_cle_o, .nand_ale_o, .nand_we_no, .nand_re_no, .nand_dq_o,
  .nand_dq_oe_o, .ce_force
);

// File: tb/tb_nand_bus_timer.sv
module tb_nand_bus_timer;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        rvalid_o, busy_o, nand_ce_no, nand_cle_o, nand_ale_o;
  logic        nand_we_no, nand_re_no, nand_dq_oe_o;
  logic [31:0] rdata_o;
  logic [7:0]  nand_dq_o, nand_dq_i = '0;
  logic        nand_rb_i = 1'b0;

  int n_chk = 0, n_bad = 0;

  nand_bus_timer dut (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung, expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // all tasks start and end just after a negedge
  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    rd_en_i = 1'b1; addr_i = a;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    d = rvalid_o ? rdata_o : 32'hDEAD_BEEF;
  endtask

  // kind: 0 data wr, 1 cmd, 2 addr, 3 data rd
  // mid: 0 none, 1 extra cmd write, 2 timing write, 3 soft reset
  task automatic run_cycle(input int kind, input logic [7:0] b, input int mid,
                           output int ns, output int nw, output int nh,
                           output int bad, output logic rv, output logic [31:0] rd);
    int iter;
    int ph;
    logic [7:0] dev;
    ns = 0; nw = 0; nh = 0; bad = 0; ph = 0;
    dev = b ^ 8'hA5;
    nand_dq_i = dev;
    addr_i = (kind == 3) ? 3'd0 : 3'(kind == 0 ? 0 : kind);
    wdata_i = {24'h0, b};
    if (kind == 3) rd_en_i = 1'b1; else wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; rd_en_i = 1'b0;
    iter = 0;
    while (busy_o && iter < 200) begin
      if (iter == 0 && mid == 1) begin wr_en_i = 1'b1; addr_i = 3'd1; wdata_i = 32'h3C; end
      else if (iter == 0 && mid == 2) begin wr_en_i = 1'b1; addr_i = 3'd6; wdata_i = 32'h0; end
      else if (iter == 0 && mid == 3) begin wr_en_i = 1'b1; addr_i = 3'd3; wdata_i = 32'h1; end
      else wr_en_i = 1'b0;
      if (!nand_we_no || !nand_re_no) begin ph = 1; nw++; end
      else if (ph == 0) ns++;
      else begin
        ph = 2; nh++;
        if (kind == 3) nand_dq_i = ~dev;  // late change must not be captured
      end
      if (nand_cle_o != (kind == 1) || nand_ale_o != (kind == 2) || nand_ce_no) bad++;
      if (kind == 3 && (nand_dq_oe_o || !nand_we_no)) bad++;
      if (kind != 3 && (!nand_dq_oe_o || nand_dq_o != b || !nand_re_no)) bad++;
      @(negedge clk_i);
      iter++;
    end
    wr_en_i = 1'b0;
    rv = rvalid_o;
    rd = rdata_o;
  endtask

  initial begin
    logic [31:0] d;
    int ns, nw, nh, bad;
    logic rv;
    logic [31:0] rd;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R10 reset state
    chk(!busy_o && nand_ce_no && nand_we_no && nand_re_no, "R10 idle pins",
        {busy_o, nand_ce_no, nand_we_no, nand_re_no}, 4'b0111);
    reg_rd(3'd6, d); chk(d == 32'hFFFF_FFFF, "R10 timing reset", d, 32'hFFFF_FFFF);
    reg_rd(3'd4, d); chk(d == 0, "R10 cfg reset", d, 0);

    // R1 R2 R3 R4 R5 R6 R7 sweep
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 4; w++)
        for (int h = 0; h < 4; h++) begin
          reg_wr(3'd6, {4'd0, 4'(w), 4'(h), 4'(s), 4'd0, 4'(s), 4'(w), 4'(h)});
          for (int k = 0; k < 4; k++) begin
            logic [7:0] b;
            int es, ew, eh;
            b = 8'(s * 37 + w * 11 + h * 5 + k);
            // read fields: setup=h width=s hold=w
            es = (k == 3) ? h + 1 : s + 1;
            ew = (k == 3) ? s + 1 : w + 1;
            eh = (k == 3) ? w + 1 : h + 1;
            run_cycle(k, b, 0, ns, nw, nh, bad, rv, rd);
            chk(ns == es && nw == ew && nh == eh, "R4 phase lengths",
                ns * 256 + nw * 16 + nh, es * 256 + ew * 16 + eh);
            chk(ns + nw + nh == s + w + h + 3, "R5 busy length", ns + nw + nh, s + w + h + 3);
            chk(bad == 0, k == 1 ? "R1 cmd lines" : k == 2 ? "R2 addr lines" : "R6 R7 R3 lines", bad, 0);
            if (k == 3)
              chk(rv && rd == {24'h0, b ^ 8'hA5}, "R3 read data", rd, {24'h0, b ^ 8'hA5});
            else
              chk(!rv, "R3 no rvalid on write", rv, 0);
          end
        end

    // R5 request during cycle ignored
    reg_wr(3'd6, 32'h0333_0333);
    run_cycle(0, 8'h5A, 1, ns, nw, nh, bad, rv, rd);
    chk(bad == 0 && ns + nw + nh == 12, "R5 cycle undisturbed", ns + nw + nh, 12);
    @(negedge clk_i);
    chk(!busy_o && !nand_cle_o, "R5 ignored request", busy_o, 0);

    // R11 timing snapshot
    reg_wr(3'd6, 32'h0222_0000);
    run_cycle(1, 8'h90, 2, ns, nw, nh, bad, rv, rd);
    chk(ns == 3 && nw == 3 && nh == 3, "R11 snapshot", ns * 256 + nw * 16 + nh, 32'h333);

    // R7 forced CE
    reg_wr(3'd4, 32'h1);
    chk(!nand_ce_no && !busy_o, "R7 forced ce", nand_ce_no, 0);
    reg_rd(3'd4, d); chk(d == 1, "R7 cfg readback", d, 1);

    // R9 soft reset mid cycle
    reg_wr(3'd6, 32'h0FFF_0FFF);
    run_cycle(2, 8'h11, 3, ns, nw, nh, bad, rv, rd);
    chk(!busy_o && nand_we_no && nand_ce_no, "R9 aborted idle",
        {busy_o, nand_we_no, nand_ce_no}, 3'b011);
    reg_rd(3'd4, d); chk(d == 0, "R9 cfg cleared", d, 0);
    reg_rd(3'd6, d); chk(d == 32'h0FFF_0FFF, "R9 timing kept", d, 32'h0FFF_0FFF);

    // R8 ready wait of 2n clocks, n=2
    nand_rb_i = 1'b0;
    reg_wr(3'd6, 32'h2000_0000);
    reg_rd(3'd5, d); chk(d == 0, "R8 busy status", d, 0);
    run_cycle(1, 8'hFF, 0, ns, nw, nh, bad, rv, rd);
    nand_rb_i = 1'b1;
    reg_rd(3'd5, d); chk(d == 0, "R8 wait start", d, 0);
    repeat (2) @(negedge clk_i);
    reg_rd(3'd5, d); chk(d == 0, "R8 wait last", d, 0);
    reg_rd(3'd5, d); chk(d == 1, "R8 wait done", d, 1);
    // n=0: follows pin on next idle clock
    reg_wr(3'd6, 32'h0000_0000);
    nand_rb_i = 1'b0;
    run_cycle(3, 8'h00, 0, ns, nw, nh, bad, rv, rd);
    nand_rb_i = 1'b1;
    @(negedge clk_i);
    reg_rd(3'd5, d); chk(d == 1, "R8 zero wait", d, 1);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule